// File: doc/BRIEF.md
# Per-Channel Burst Reduction Filter

The filter sits between the result path of a multi-channel converter and the result FIFO. Raw conversions arrive one per accepted cycle, each tagged with a channel number. For every channel, a configuration word picks a reduction and a burst length. The reduction is pass-through, arithmetic mean or median. The burst length is 1, 2, 4 or 8 consecutive conversions. When the last conversion of a burst has been collected, the block emits one reduced result tagged with the burst's channel. A busy flag is raised while a burst is still incomplete.

The channel number and the configuration of a burst are captured when its first sample is accepted. Later samples of the same burst are credited to that channel, whatever channel number comes with them, and changes to the configuration word take effect only from the next burst. The mean truncates toward zero. For an even burst length the median takes the lower of the two middle values. The sample width is a parameter. It is meant to be 10 or 12 bits, with 12 as the default.

Top module: `burst_reduce_filter`

## Requirements
- R1: While reset is held and in the first cycle after it, out_valid and busy are low.
- R2: For channel c, the burst-length code sits in cfg_word bits [2c+1:2c] and the reduction code sits in bits [2*NCH+2c+1:2*NCH+2c], which is [17+2c:16+2c] for 8 channels. Length codes 0, 1, 2 and 3 select 1, 2, 4 and 8 samples. Reduction codes are 0 for none, 1 for mean and 2 for median.
- R3: Reduction code 0 and the reserved code 3 both pass every sample through on its own, whatever the length code. So does a mean or median with length code 0. The sample and its channel appear on out_data and out_chan with out_valid one cycle after in_valid.
- R4: In mean mode with N samples, out_data is the sum of the N samples divided by N and truncated. It appears one cycle after the last sample is accepted.
- R5: In median mode with N samples, out_data is the element at position (N-1)/2 of the samples sorted in ascending order. For an even N this is the lower middle value. It appears one cycle after the last sample is accepted.
- R6: busy rises in the cycle after the first sample of a burst longer than one is accepted. It stays high until the cycle in which the result appears, when it is low. out_valid is a one-cycle pulse for each completed burst and is low at all other times.
- R7: The channel, reduction and length of a burst are captured at its first sample. Changes to cfg_word, and the in_chan values of later samples, do not change that burst's result or out_chan.
- R8: Cycles with in_valid low neither advance nor disturb a burst that is in progress, whatever in_chan and in_data hold.
- R9: Full-scale samples reduce without overflow. Eight samples of 2^W-1 give a mean of 2^W-1, and eight zeros give 0 (W = 12 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 4*NCH | Per-channel length codes (low half) and reduction codes (high half) |
| in_valid | input | 1 | A raw sample is offered this cycle |
| in_chan | input | $clog2(NCH) | Channel number of the sample |
| in_data | input | W | Raw sample |
| out_valid | output | 1 | One-cycle pulse: reduced result present |
| out_chan | output | $clog2(NCH) | Channel of the reduced result |
| out_data | output | W | Reduced result |
| busy | output | 1 | A burst has been started but not completed |

## Verification
The assertions assume that in_data is never unknown once reset is released. They also assume that a channel's burst is not interleaved with samples meant for another channel. The filter does not detect such interleaving: it credits every sample in a burst to the burst's channel. The stimulus therefore drives a known sample value in every cycle. It sends each burst as a run of samples, with optional idle gaps, and uses the length that the bench itself derives from the configuration word at the burst's first sample. Mid-burst channel and configuration changes are applied on purpose, only to show that they are ignored.

// File: rtl/brf_pkg.sv
package brf_pkg;

  localparam int CODE_W    = 2;
  localparam int BURST_MAX = 8;

  typedef enum logic [1:0] {
    RED_PASS   = 2'd0,
    RED_MEAN   = 2'd1,
    RED_MEDIAN = 2'd2
  } red_e;

  // reduction code to reduction kind; the reserved code falls back to pass
  function automatic red_e f_red_kind(input logic [CODE_W-1:0] mode_code);
    case (mode_code)
      2'd1:    return RED_MEAN;
      2'd2:    return RED_MEDIAN;
      default: return RED_PASS;
    endcase
  endfunction

  // log2 of the burst length actually used: pass-through always takes one sample
  function automatic logic [CODE_W-1:0] f_eff_log2(input logic [CODE_W-1:0] mode_code,
                                                   input logic [CODE_W-1:0] cnt_code);
    return (f_red_kind(mode_code) == RED_PASS) ? '0 : cnt_code;
  endfunction

  // position of the lower middle element in an ascending sort of n elements
  function automatic int f_mid_pos(input int n);
    return (n - 1) >> 1;
  endfunction

endpackage

// File: rtl/brf_cfg_decode.sv
module brf_cfg_decode
  import brf_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CHW = $clog2(NCH)
) (
  input  logic [4*NCH-1:0] cfg_word,
  input  logic [CHW-1:0]   chan,
  output logic [1:0]       eff_log2,
  output red_e             kind
);

  localparam int MODE_BASE = 2*NCH;

  logic [1:0] cnt_f  [NCH];
  logic [1:0] mode_f [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_field
    assign cnt_f[c]  = cfg_word[2*c +: 2];
    assign mode_f[c] = cfg_word[MODE_BASE + 2*c +: 2];
  end

  assign kind     = f_red_kind(mode_f[chan]);
  assign eff_log2 = f_eff_log2(mode_f[chan], cnt_f[chan]);

endmodule

// File: rtl/brf_collect.sv
module brf_collect
  import brf_pkg::*;
#(
  parameter int W     = 12,
  parameter int CHW   = 3,
  parameter int DEPTH = BURST_MAX,
  parameter int IDXW  = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [CHW-1:0] in_chan,
  input  logic [W-1:0]   in_data,
  input  logic [1:0]     dec_log2,
  input  red_e           dec_kind,
  output logic           busy,
  output logic [CHW-1:0] cur_chan,
  output logic [1:0]     cur_log2,
  output red_e           cur_kind,
  output logic           last,
  output logic [W-1:0]   vals [DEPTH]
);

  logic            active;
  logic [IDXW-1:0] idx;
  logic [CHW-1:0]  lat_chan;
  logic [1:0]      lat_log2;
  red_e            lat_kind;
  logic [W-1:0]    hold_q [DEPTH];
  logic [IDXW:0]   n_cur;

  assign cur_chan = active ? lat_chan : in_chan;
  assign cur_log2 = active ? lat_log2 : dec_log2;
  assign cur_kind = active ? lat_kind : dec_kind;
  assign n_cur    = (IDXW+1)'(1) << cur_log2;
  assign last     = in_valid && ({1'b0, idx} == n_cur - 1'b1);
  assign busy     = active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      idx      <= '0;
      lat_chan <= '0;
      lat_log2 <= '0;
      lat_kind <= RED_PASS;
      for (int k = 0; k < DEPTH; k++) hold_q[k] <= '0;
    end else if (in_valid) begin
      if (last) begin
        active <= 1'b0;
        idx    <= '0;
      end else begin
        active      <= 1'b1;
        idx         <= idx + 1'b1;
        hold_q[idx] <= in_data;
        if (!active) begin
          lat_chan <= in_chan;
          lat_log2 <= dec_log2;
          lat_kind <= dec_kind;
        end
      end
    end
  end

  // the element being accepted now stands in for the slot it would fill
  for (genvar k = 0; k < DEPTH; k++) begin : g_view
    assign vals[k] = (IDXW'(k) == idx) ? in_data : hold_q[k];
  end

  assert_idx_in_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx != '0) && ({1'b0, idx} < n_cur));

  assert_idle_idx_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (idx == '0));

  assert_latch_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(lat_chan) && $stable(lat_log2) && $stable(lat_kind)));

  assert_gap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !in_valid) |=> (busy && $stable(idx)));

endmodule

// File: rtl/brf_reduce.sv
module brf_reduce
  import brf_pkg::*;
#(
  parameter int W     = 12,
  parameter int DEPTH = BURST_MAX,
  parameter int IDXW  = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic [W-1:0] vals [DEPTH],
  input  logic [1:0]   log2n,
  input  red_e         kind,
  output logic [W-1:0] result
);

  localparam int SUMW = W + IDXW;

  int              n;
  logic [SUMW-1:0] sum;
  logic [W-1:0]    mean_v;
  logic [IDXW:0]   rank [DEPTH];
  logic [IDXW:0]   mid;
  logic [DEPTH-1:0] med_sel;
  logic [W-1:0]    median_v;

  assign n   = 1 << log2n;
  assign mid = (IDXW+1)'(f_mid_pos(n));

  always_comb begin
    sum = '0;
    for (int k = 0; k < DEPTH; k++)
      if (k < n) sum = sum + SUMW'(vals[k]);
  end

  assign mean_v = W'(sum >> log2n);

  // stable rank: smaller values first, ties ordered by slot
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      rank[i] = '0;
      for (int j = 0; j < DEPTH; j++)
        if (j != i && j < n &&
            ((vals[j] < vals[i]) || (vals[j] == vals[i] && j < i)))
          rank[i] = rank[i] + 1'b1;
    end
  end

  always_comb begin
    median_v = '0;
    for (int i = 0; i < DEPTH; i++) begin
      med_sel[i] = (i < n) && (rank[i] == mid);
      if (med_sel[i]) median_v = median_v | vals[i];
    end
  end

  always_comb begin
    case (kind)
      RED_MEAN:   result = mean_v;
      RED_MEDIAN: result = median_v;
      default:    result = vals[0];
    endcase
  end

  assert_median_unique_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && kind == RED_MEDIAN) |-> $onehot(med_sel));

endmodule

// File: rtl/burst_reduce_filter.sv
module burst_reduce_filter
  import brf_pkg::*;
#(
  parameter int W   = 12,
  parameter int NCH = 8,
  parameter int CHW = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4*NCH-1:0] cfg_word,
  input  logic             in_valid,
  input  logic [CHW-1:0]   in_chan,
  input  logic [W-1:0]     in_data,
  output logic             out_valid,
  output logic [CHW-1:0]   out_chan,
  output logic [W-1:0]     out_data,
  output logic             busy
);

  localparam int DEPTH = BURST_MAX;

  logic [1:0]     dec_log2;
  red_e           dec_kind;
  logic [CHW-1:0] cur_chan;
  logic [1:0]     cur_log2;
  red_e           cur_kind;
  logic           last;
  logic [W-1:0]   vals [DEPTH];
  logic [W-1:0]   reduced;

  brf_cfg_decode #(.NCH(NCH), .CHW(CHW)) u_decode (
    .cfg_word (cfg_word),
    .chan     (in_chan),
    .eff_log2 (dec_log2),
    .kind     (dec_kind)
  );

  brf_collect #(.W(W), .CHW(CHW), .DEPTH(DEPTH)) u_collect (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_chan  (in_chan),
    .in_data  (in_data),
    .dec_log2 (dec_log2),
    .dec_kind (dec_kind),
    .busy     (busy),
    .cur_chan (cur_chan),
    .cur_log2 (cur_log2),
    .cur_kind (cur_kind),
    .last     (last),
    .vals     (vals)
  );

  brf_reduce #(.W(W), .DEPTH(DEPTH)) u_reduce (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (last),
    .vals   (vals),
    .log2n  (cur_log2),
    .kind   (cur_kind),
    .result (reduced)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= last;
      if (last) begin
        out_chan <= cur_chan;
        out_data <= reduced;
      end
    end
  end

  assert_out_needs_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  assert_pass_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy && dec_kind == RED_PASS) |=> (out_valid && out_chan == $past(in_chan)
                                                     && out_data == $past(in_data)));

  assert_result_ends_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !busy);

  assert_busy_starts_on_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(in_valid) && !out_valid));

endmodule

// File: tb/burst_reduce_filter_bench.sv
module burst_reduce_filter_bench;
  localparam int W   = 12;
  localparam int NCH = 8;
  localparam int CHW = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [4*NCH-1:0] cfg_word = '0;
  logic             in_valid = 1'b0;
  logic [CHW-1:0]   in_chan = '0;
  logic [W-1:0]     in_data = '0;
  logic             out_valid;
  logic [CHW-1:0]   out_chan;
  logic [W-1:0]     out_data;
  logic             busy;

  burst_reduce_filter #(.W(W), .NCH(NCH)) u_burst_reduce_filter (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .in_valid(in_valid),
    .in_chan(in_chan), .in_data(in_data), .out_valid(out_valid),
    .out_chan(out_chan), .out_data(out_data), .busy(busy)
  );

  always #4 clk = ~clk;

  int    vec = 0;
  int    bad = 0;
  bit    exp_valid = 0;
  bit    exp_busy = 0;
  int    exp_chan = 0;
  int    exp_data = 0;
  string exp_tag = "R3";
  string phase = "R1";
  bit    m_active = 0;
  int    m_q[$];
  int    m_chan = 0;
  int    m_n = 1;
  int    m_kind = 0;
  int    full = (1 << W) - 1;

  // R2: reduction code in the high half, length code in the low half
  function automatic int kind_of(int ch);
    int mode = int'((cfg_word >> (2*NCH + 2*ch)) & 3);
    return (mode == 1 || mode == 2) ? mode : 0;
  endfunction

  function automatic int len_of(int ch);
    if (kind_of(ch) == 0) return 1;
    return 1 << int'((cfg_word >> (2*ch)) & 3);
  endfunction

  function automatic void set_ch(int ch, int mode, int cnt);
    cfg_word[2*ch +: 2]         = 2'(cnt);
    cfg_word[2*NCH + 2*ch +: 2] = 2'(mode);
  endfunction

  task automatic check(string tag, string what, int act, int expv);
    vec++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic step(bit v, int ch, int d);
    int s[$];
    int sum;
    @(negedge clk);
    check({"R6/", phase}, "busy", int'(busy), int'(exp_busy));
    check({"R6/", phase}, "out_valid", int'(out_valid), int'(exp_valid));
    if (exp_valid) begin
      check({exp_tag, "/", phase}, "out_chan", int'(out_chan), exp_chan);
      check({exp_tag, "/", phase}, "out_data", int'(out_data), exp_data);
    end
    in_valid = v;
    in_chan  = CHW'(ch);
    in_data  = W'(d);
    exp_valid = 0;
    if (v) begin
      if (!m_active) begin
        m_chan = ch;
        m_kind = kind_of(ch);
        m_n    = len_of(ch);
        m_q.delete();
      end
      m_q.push_back(d);
      if (m_q.size() == m_n) begin
        exp_valid = 1;
        exp_busy  = 0;
        m_active  = 0;
        exp_chan  = m_chan;
        if (m_kind == 1) begin
          sum = 0;
          foreach (m_q[i]) sum += m_q[i];
          exp_data = sum / m_n;
          exp_tag  = (m_n == 1) ? "R3" : "R4";
        end else if (m_kind == 2) begin
          s = m_q;
          s.sort();
          exp_data = s[(m_n - 1) / 2];
          exp_tag  = (m_n == 1) ? "R3" : "R5";
        end else begin
          exp_data = d;
          exp_tag  = "R3";
        end
      end else begin
        m_active = 1;
        exp_busy = 1;
      end
    end
    @(posedge clk);
    #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, int'($urandom % NCH), int'($urandom % (1 << W)));
  endtask

  task automatic burst(int ch, bit gaps);
    int n = len_of(ch);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 3 == 0)) idle(1 + int'($urandom % 2));
      step(1, ch, int'($urandom % (1 << W)));
    end
  endtask

  task automatic burst_fixed(int ch, int d[$]);
    foreach (d[i]) step(1, ch, d[i]);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state, during and just after reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "out_valid in reset", int'(out_valid), 0);
    check("R1", "busy in reset", int'(busy), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2);

    // R3: no reduction with a nonzero length code, then reserved code 3
    phase = "R3";
    for (int c = 0; c < NCH; c++) set_ch(c, 0, 3);
    for (int c = 0; c < NCH; c++) burst(c, 0);
    set_ch(5, 3, 2);
    burst(5, 0); burst(5, 0);
    set_ch(2, 1, 0);
    burst(2, 0);
    idle(2);

    // R4: mean at each length, including a truncating case
    phase = "R4";
    for (int cnt = 1; cnt < 4; cnt++) begin
      set_ch(2, 1, cnt);
      burst(2, 0); burst(2, 0);
    end
    set_ch(3, 1, 1);
    burst_fixed(3, '{10, 13});
    idle(1);

    // R5: median at each length, lower middle and duplicates
    phase = "R5";
    for (int cnt = 1; cnt < 4; cnt++) begin
      set_ch(6, 2, cnt);
      burst(6, 0); burst(6, 0);
    end
    set_ch(4, 2, 2);
    burst_fixed(4, '{900, 100, 500, 700});
    set_ch(4, 2, 3);
    burst_fixed(4, '{7, 7, 3, 7, 1, 9, 3, 7});
    idle(1);

    // R2: every channel with its own mode and length
    phase = "R2";
    for (int c = 0; c < NCH; c++) set_ch(c, c % 3, (c + 1) % 4);
    for (int c = NCH - 1; c >= 0; c--) burst(c, 0);
    idle(1);

    // R7: channel and configuration changes mid-burst
    phase = "R7";
    set_ch(1, 1, 3);
    step(1, 1, 100); step(1, 1, 200); step(1, 1, 300);
    set_ch(1, 0, 0);
    set_ch(4, 2, 1);
    for (int i = 0; i < 5; i++) step(1, 4, 400 + 37*i);
    burst(4, 0);
    idle(1);

    // R8: idle gaps inside bursts
    phase = "R8";
    set_ch(0, 1, 3); set_ch(7, 2, 3);
    burst(0, 1); burst(7, 1); burst(0, 1);
    idle(1);

    // R9: full scale and zero
    phase = "R9";
    burst_fixed(0, '{full, full, full, full, full, full, full, full});
    burst_fixed(7, '{full, full, full, full, full, full, full, full});
    burst_fixed(0, '{0, 0, 0, 0, 0, 0, 0, 0});
    idle(1);

    // mixed random configurations and bursts
    phase = "R2";
    for (int b = 0; b < 200; b++) begin
      cfg_word = $urandom;
      burst(int'($urandom % NCH), 1);
      if ($urandom % 4 == 0) idle(1);
    end
    idle(3);

    summary();
    $finish;
  end

endmodule